// File: doc/BRIEF.md
# Interrupt Request and In-Service Tracker

This block keeps the bookkeeping for 256 interrupt vectors in front of one processor. Incoming requests arrive as a vector number with a one-cycle strobe and a trigger flag. Each accepted request sets a bit in a pending bitmap and records its trigger kind in a trigger bitmap. The block presents the best pending vector to the processor over a valid/acknowledge handshake. On acknowledge, the vector moves from the pending bitmap to the in-service bitmap.

Software sees the three 256-bit bitmaps as read-only 32-bit words on a small register bus with a 12-bit address, which covers a 4 KB window. A write of any value to a dedicated end-of-interrupt register retires the highest-numbered vector that is in service. Reads are combinational: `bus_rdata` reflects the current state at `bus_addr`. Registers are decoded on `bus_addr[11:4]`, so each register sits on a 16-byte boundary and address bits 3:0 are ignored.

Top module: `irq_vector_tracker`

## Requirements
- R1: After reset, every bitmap word reads zero and `int_valid` is low.
- R2: A request strobe for vector v sets pending bit v from the next cycle. A request for a vector that is already pending is merged into that bit, so one acknowledge clears it.
- R3: When a request is recorded into a clear pending bit, trigger bit v takes the value of `req_level` (1 = level, 0 = edge). A merged request leaves the trigger bit unchanged.
- R4: While nothing is in service, `int_valid` is high whenever any vector is pending, and `int_vector` is the highest-numbered pending vector.
- R5: The class of a vector is bits 7:4 of its number. A pending vector is offered only if its class is strictly greater than the class of the highest-numbered in-service vector.
- R6: `int_ack` while `int_valid` is high clears the offered pending bit and sets its in-service bit at the same clock edge.
- R7: A bus write of any data to offset 0x0B0 clears the highest-numbered in-service bit. If no in-service bit is set, the write has no effect.
- R8: Reading offset 0x0B0, or any address that no register decodes, returns zero. Bus writes to bitmap offsets change no state.
- R9: Bitmap word k covers vectors 32k to 32k+31, with bit i of the word holding vector 32k+i. The in-service words sit at 0x100 + 0x10·k, the trigger words at 0x180 + 0x10·k, and the pending words at 0x200 + 0x10·k, for k from 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_vector | input | 8 | Requested vector number |
| req_level | input | 1 | Trigger kind of the request: 1 = level, 0 = edge |
| int_valid | output | 1 | A vector is offered to the processor |
| int_vector | output | 8 | Offered vector number |
| int_ack | input | 1 | Processor accepts the offered vector |
| bus_addr | input | 12 | Register address inside the 4 KB window |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Write data (only the end-of-interrupt register acts on a write) |
| bus_rdata | output | 32 | Read data for `bus_addr` |

## Verification
Directed sequences first isolate single effects:
- A repeated request with a different trigger flag shows merging.
- Two vectors in the same class shows the strict-class gate, which an off-by-one comparison would get wrong.
- A higher-class request arriving over an in-service vector shows nesting.
- Two end-of-interrupt writes in a row show that the highest in-service bit is retired, not the oldest.

A random phase then drives requests, acknowledges, end-of-interrupt writes and writes to bitmap words together in the same cycles. This exposes ordering faults that the directed cases cannot reach, such as a request and an acknowledge for the same vector at one edge, or an end-of-interrupt write coinciding with an acknowledge. A behavioural model is compared with the offer every cycle and with the read words sampled through the bus.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
    localparam int NUM_VEC   = 256;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 12;
    localparam int VEC_W     = $clog2(NUM_VEC);
    localparam int NUM_WORDS = NUM_VEC / WORD_W;
    localparam int CLASS_W   = 4;

    // Register offsets (byte addresses, 16-byte aligned)
    localparam logic [ADDR_W-1:0] OFS_EOI = 12'h0B0;
    localparam logic [ADDR_W-1:0] OFS_ISR = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_TMR = 12'h180;
    localparam logic [ADDR_W-1:0] OFS_IRR = 12'h200;

    typedef struct packed {
        logic [NUM_VEC-1:0] pend;   // pending requests
        logic [NUM_VEC-1:0] svc;    // in service
        logic [NUM_VEC-1:0] trig;   // 1 = level, 0 = edge
    } trk_state_t;
endpackage

// File: rtl/irq_trk_top_bit.sv
// Finds the highest-numbered set bit of a vector.
module irq_trk_top_bit #(
    parameter int N = 256,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  bits,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (bits[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_trk_regmux.sv
// Read decode for the three bitmaps; low 4 address bits ignored.
module irq_trk_regmux
    import irq_trk_pkg::*;
#(
    parameter int NV = NUM_VEC,
    parameter int WW = WORD_W,
    parameter int AW = ADDR_W,
    localparam int NW = NV / WW,
    localparam int WI = $clog2(NW)
) (
    input  logic [AW-1:0] addr,
    input  logic [NV-1:0] svc,
    input  logic [NV-1:0] trig,
    input  logic [NV-1:0] pend,
    output logic [WW-1:0] rdata
);
    localparam int LO = 4;  // 16-byte register spacing

    logic [WI-1:0] widx;
    logic [AW-1:0] gbase;
    logic [WW-1:0] svc_w   [NW];
    logic [WW-1:0] trig_w  [NW];
    logic [WW-1:0] pend_w  [NW];

    for (genvar k = 0; k < NW; k++) begin : g_words
        assign svc_w[k]  = svc [k*WW +: WW];
        assign trig_w[k] = trig[k*WW +: WW];
        assign pend_w[k] = pend[k*WW +: WW];
    end

    assign widx  = addr[LO +: WI];
    assign gbase = {addr[AW-1:LO+WI], {(LO+WI){1'b0}}};

    always_comb begin
        rdata = '0;
        if (gbase == OFS_ISR)      rdata = svc_w[widx];
        else if (gbase == OFS_TMR) rdata = trig_w[widx];
        else if (gbase == OFS_IRR) rdata = pend_w[widx];
    end
endmodule

// File: rtl/irq_vector_tracker.sv
module irq_vector_tracker
    import irq_trk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VEC_W-1:0]  req_vector,
    input  logic              req_level,
    output logic              int_valid,
    output logic [VEC_W-1:0]  int_vector,
    input  logic              int_ack,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata
);
    trk_state_t st_q, st_d;

    logic             pend_any, svc_any;
    logic [VEC_W-1:0] pend_top, svc_top;
    logic             ack_fire, eoi_fire;
    logic [NUM_VEC-1:0] pend_kept;

    irq_trk_top_bit #(.N(NUM_VEC)) u_pend_top (
        .bits (st_q.pend), .any (pend_any), .idx (pend_top));

    irq_trk_top_bit #(.N(NUM_VEC)) u_svc_top (
        .bits (st_q.svc), .any (svc_any), .idx (svc_top));

    irq_trk_regmux u_rd (
        .addr (bus_addr), .svc (st_q.svc), .trig (st_q.trig),
        .pend (st_q.pend), .rdata (bus_rdata));

    // Offer: class gate against the highest in-service vector
    always_comb begin
        int_vector = pend_top;
        int_valid  = pend_any &&
                     (!svc_any ||
                      (pend_top[VEC_W-1 -: CLASS_W] > svc_top[VEC_W-1 -: CLASS_W]));
    end

    assign ack_fire = int_ack && int_valid;
    assign eoi_fire = bus_we && (bus_addr[ADDR_W-1:4] == OFS_EOI[ADDR_W-1:4]);

    // bus_wdata only matters as a write strobe carrier: any value retires
    logic unused_wdata;
    assign unused_wdata = ^bus_wdata;

    always_comb begin
        st_d = st_q;
        if (ack_fire) st_d.pend[int_vector] = 1'b0;
        pend_kept = st_d.pend;
        if (eoi_fire && svc_any) st_d.svc[svc_top] = 1'b0;
        if (ack_fire) st_d.svc[int_vector] = 1'b1;
        if (req_valid) begin
            if (!pend_kept[req_vector]) st_d.trig[req_vector] = req_level;
            st_d.pend[req_vector] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // ---------------- assertions ----------------
    a_r1_idle_after_reset: assert property (@(posedge clk)
        disable iff (!rst_n) (st_q.pend == '0) |-> !int_valid);

    a_r2_request_recorded: assert property (@(posedge clk)
        disable iff (!rst_n) req_valid |=> st_q.pend[$past(req_vector)]);

    a_r4_offer_is_pending: assert property (@(posedge clk)
        disable iff (!rst_n) int_valid |-> st_q.pend[int_vector]);

    a_r5_class_above_service: assert property (@(posedge clk)
        disable iff (!rst_n) (int_valid && svc_any) |->
            (int_vector[VEC_W-1 -: CLASS_W] > svc_top[VEC_W-1 -: CLASS_W]));

    a_r6_ack_enters_service: assert property (@(posedge clk)
        disable iff (!rst_n) ack_fire |=> st_q.svc[$past(int_vector)]);

    a_r7_eoi_retires_top: assert property (@(posedge clk)
        disable iff (!rst_n) (eoi_fire && svc_any) |=> !st_q.svc[$past(svc_top)]);

    a_r8_bitmap_write_ignored: assert property (@(posedge clk)
        disable iff (!rst_n) (bus_we && !eoi_fire && !req_valid && !ack_fire)
            |=> $stable(st_q));
endmodule

// File: tb/sim_irq_vector_tracker.sv
module sim_irq_vector_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_vector = '0;
    logic        req_level = 1'b0;
    logic        int_valid;
    logic [7:0]  int_vector;
    logic        int_ack = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    irq_vector_tracker u0 (
        .clk, .rst_n, .req_valid, .req_vector, .req_level,
        .int_valid, .int_vector, .int_ack,
        .bus_addr, .bus_we, .bus_wdata, .bus_rdata);

    // ---------------- behavioural reference ----------------
    bit m_pend [256];
    bit m_svc  [256];
    bit m_trig [256];

    function automatic int top_of(input bit a [256]);
        for (int i = 255; i >= 0; i--) if (a[i]) return i;
        return -1;
    endfunction

    function automatic int m_offer();
        int p = top_of(m_pend);
        int s = top_of(m_svc);
        if (p < 0) return -1;
        if (s < 0 || (p / 16) > (s / 16)) return p;
        return -1;
    endfunction

    function automatic logic [31:0] m_word(input logic [11:0] a);
        logic [31:0] w = '0;
        int k = int'(a[6:4]);
        for (int i = 0; i < 32; i++) begin
            if (a[11:7] == 5'b00010) w[i] = m_svc[32*k+i];
            else if (a[11:7] == 5'b00011) w[i] = m_trig[32*k+i];
            else if (a[11:7] == 5'b00100) w[i] = m_pend[32*k+i];
        end
        return w;
    endfunction

    always @(posedge clk) begin : model
        int off;
        int s;
        bit was;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) begin
                m_pend[i] = 0; m_svc[i] = 0; m_trig[i] = 0;
            end
        end else begin
            off = m_offer();
            s   = top_of(m_svc);
            if (int_ack && off >= 0) m_pend[off] = 0;
            if (bus_we && bus_addr[11:4] == 8'h0B && s >= 0) m_svc[s] = 0;
            if (int_ack && off >= 0) m_svc[off] = 1;
            if (req_valid) begin
                was = m_pend[req_vector];
                if (!was) m_trig[req_vector] = req_level;
                m_pend[req_vector] = 1;
            end
        end
    end

    // ---------------- checking ----------------
    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Offer compared with the model every cycle (R4 R5)
    always @(negedge clk) begin
        int o;
        if (rst_n && !done) begin
            o = m_offer();
            if (o < 0) check(!int_valid, "R4 R5 offer valid", {31'b0, int_valid}, 0);
            else check(int_valid && int_vector == 8'(o), "R4 R5 offer vector",
                       {23'b0, int_valid, int_vector}, {23'b0, 1'b1, 8'(o)});
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic request(input logic [7:0] v, input logic lvl);
        req_valid = 1'b1; req_vector = v; req_level = lvl;
        tick();
        req_valid = 1'b0;
    endtask

    task automatic ack();
        int_ack = 1'b1;
        tick();
        int_ack = 1'b0;
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
        bus_addr = a;
        #1;
        check(bus_rdata == exp, req, bus_rdata, exp);
    endtask

    task automatic rd_model(input logic [11:0] a, input string req);
        rd(a, m_word(a), req);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(!int_valid, "R1 int_valid after reset", {31'b0, int_valid}, 0);
        for (int k = 0; k < 8; k++) begin
            rd(12'h100 + 12'(16*k), 0, "R1 in-service word");
            rd(12'h180 + 12'(16*k), 0, "R1 trigger word");
            rd(12'h200 + 12'(16*k), 0, "R1 pending word");
        end

        // R7: EOI with nothing in service has no effect
        bus_write(12'h0B0, 32'h1234_5678);
        rd(12'h100, 0, "R7 eoi on empty");
        check(!int_valid, "R7 eoi on empty offer", {31'b0, int_valid}, 0);

        // R2 R3 R9: request 0x21 edge, repeat as level is merged
        request(8'h21, 1'b0);
        request(8'h21, 1'b1);
        rd(12'h210, 32'h0000_0002, "R2 R9 pending word1 bit1");
        rd(12'h190, 32'h0, "R3 merged request keeps edge");
        check(int_valid && int_vector == 8'h21, "R4 single pending offered",
              {23'b0, int_valid, int_vector}, 32'h121);

        // R3 R9: level request 0x95 -> word 4 bit 21
        request(8'h95, 1'b1);
        rd(12'h1C0, 32'h0020_0000, "R3 R9 trigger word4");
        check(int_vector == 8'h95, "R4 highest pending", {24'b0, int_vector}, 32'h95);

        // R6: acknowledge moves 0x95 into service
        ack();
        rd(12'h140, 32'h0020_0000, "R6 in-service word4");
        rd(12'h240, 32'h0, "R6 pending word4 cleared");

        // R5: same class 9 held off, lower class 2 held off
        request(8'h9A, 1'b0);
        check(!int_valid, "R5 same class not offered", {31'b0, int_valid}, 0);

        // R5: higher class nests
        request(8'hA0, 1'b0);
        check(int_valid && int_vector == 8'hA0, "R5 higher class offered",
              {23'b0, int_valid, int_vector}, 32'h1A0);
        ack();
        rd(12'h150, 32'h0000_0001, "R6 in-service word5");

        // R7: EOI retires the highest (0xA0), then 0x95
        bus_write(12'h0B0, 32'hDEAD_BEEF);
        rd(12'h150, 32'h0, "R7 eoi clears highest");
        rd(12'h140, 32'h0020_0000, "R7 lower stays in service");
        check(!int_valid, "R5 0x9A still blocked", {31'b0, int_valid}, 0);
        bus_write(12'h0B0, 32'h0);
        rd(12'h140, 32'h0, "R7 second eoi");
        check(int_valid && int_vector == 8'h9A, "R4 after eoi offers 0x9A",
              {23'b0, int_valid, int_vector}, 32'h19A);

        // R8: writes to bitmaps ignored, EOI and unmapped reads zero
        bus_write(12'h200, 32'hFFFF_FFFF);
        bus_write(12'h100, 32'hFFFF_FFFF);
        bus_write(12'h180, 32'hFFFF_FFFF);
        rd(12'h200, 32'h0, "R8 pending write ignored");
        rd(12'h100, 32'h0, "R8 in-service write ignored");
        rd(12'h180, 32'h0, "R8 trigger write ignored");
        rd(12'h210, 32'h0000_0002, "R8 pending word1 intact");
        rd(12'h0B0, 32'h0, "R8 eoi reads zero");
        rd(12'h300, 32'h0, "R8 unmapped reads zero");

        // Random phase: overlapping requests, acks, eoi and bitmap writes
        for (int n = 0; n < 2000; n++) begin
            int r = int'($urandom % 16);
            req_valid  = (r < 7);
            req_vector = 8'($urandom);
            req_level  = 1'($urandom);
            int_ack    = ($urandom % 3) == 0;
            bus_we     = ($urandom % 5) == 0;
            bus_addr   = (($urandom % 2) == 0) ? 12'h0B0
                         : (12'h100 + 12'(16 * ($urandom % 24)));
            bus_wdata  = $urandom;
            tick();
            req_valid = 1'b0; int_ack = 1'b0; bus_we = 1'b0;
            if (n % 8 == 0) begin
                rd_model(12'h100 + 12'(16 * ($urandom % 24)), "R2 R3 R6 R7 R9 random word");
            end
        end

        // Final sweep of every word against the model
        for (int k = 0; k < 24; k++) rd_model(12'h100 + 12'(16*k), "R9 final sweep");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule